// File: doc/BRIEF.md
# Instruction Queue Head Controller

This block sits at the head of a dock's circular instruction queue. Instruction words enter through a single arrival register that has nothing buffering it from the fabric. Ordinary instructions then pass into a ring buffer and from there into an on-deck register. The on-deck register presents the next instruction to the execution sequencer. When the sequencer accepts an instruction it can ask for that instruction to be relooped, which writes the word back into the tail of the ring.

Four control instructions never reach the sequencer. An interrupt or a massacre parks in the arrival register until the on-deck instruction is marked interruptible. An interrupt then drops only the on-deck instruction, which still reloops if asked. A massacre empties the whole queue. A clog travels down the queue like any other instruction, but once it is on deck it blocks execution until an unclog in the arrival register meets it. At that point both words are retired. An unclog that never meets a clog blocks the arrival register for good.

Top module: `iqh_head`

## Requirements
- R1: While `rst_n` is low at a clock edge, all stages are emptied, including any pending control word. After that edge `od_valid` is 0, `fifo_empty` is 1 and `in_ready` is 1.
- R2: Ordinary instructions leave through `od_word`, unchanged in all 37 bits, in the order they were accepted. A presented word stays valid and stable until `od_ready` takes it.
- R3: The ring holds at most DEPTH words. `fifo_full` and `fifo_empty` report its occupancy. An ordinary word in the arrival register that finds no slot holds `in_ready` low.
- R4: When the sequencer takes the on-deck word with `od_reloop` high, that word is appended to the ring tail. In that cycle it takes priority over a word from the arrival register.
- R5: Word layout: bits 36:26 are the dispatch path, bit 25 is the interruptible flag, and bits 24:21 are the kind code. Codes 0xC, 0xD, 0xE and 0xF are interrupt, massacre, clog and unclog. Any other code is an ordinary instruction.
- R6: An interrupt or massacre waits in the arrival register, with `in_ready` low, until the on-deck word is ordinary and has bit 25 set. Instructions already queued keep executing while it waits.
- R7: When an interrupt fires, the on-deck word is dropped without being offered (`od_valid` low). If `od_reloop` is high in that cycle, the word is appended to the ring tail.
- R8: When a massacre fires, the ring, the on-deck word and the massacre itself are all discarded.
- R9: A clog on deck is never offered to the sequencer. It stays there, and nothing behind it executes.
- R10: An unclog in the arrival register waits for a clog on deck. Then both are retired and execution resumes with the next queued word.
- R11: An unclog that finds no clog on deck holds `in_ready` low for as long as no clog arrives, with no timeout.
- R12: A clog on deck with bit 25 set does not release a waiting interrupt or massacre.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Incoming instruction word present |
| in_ready | output | 1 | Arrival register can take a word this cycle |
| in_word | input | 37 | Path plus instruction |
| od_valid | output | 1 | On-deck instruction offered to the sequencer |
| od_ready | input | 1 | Sequencer takes the on-deck instruction |
| od_word | output | 37 | On-deck instruction word |
| od_reloop | input | 1 | Write the taken or interrupted word back to the ring |
| fifo_full | output | 1 | Ring holds DEPTH words |
| fifo_empty | output | 1 | Ring holds no word |

## Verification
The bench builds the block with DEPTH set to 3. With that depth the ring fills after only a few stalled cycles, so arrival back-pressure and the reloop-on-full case come up often. Because 3 is not a power of two, the pointer wrap also runs through a non-binary boundary. Directed sequences park interrupts, massacres, clogs and unclogs against chosen on-deck words. Random phases, reset every 64 cycles to clear the intended deadlocks, mix reloop requests with control words on every cycle.

// File: rtl/iqh_pkg.sv
// Shared constants and the instruction-kind type for the queue head.
// Assumes the kind field is four bits wide and sits just below the
// interruptible flag, at the top of the instruction field.
package iqh_pkg;

    localparam int KIND_W = 4;

    localparam logic [KIND_W-1:0] CODE_INT    = 4'hC;
    localparam logic [KIND_W-1:0] CODE_MASS   = 4'hD;
    localparam logic [KIND_W-1:0] CODE_CLOG   = 4'hE;
    localparam logic [KIND_W-1:0] CODE_UNCLOG = 4'hF;

    typedef enum logic [2:0] {
        KIND_PLAIN  = 3'd0,
        KIND_INT    = 3'd1,
        KIND_MASS   = 3'd2,
        KIND_CLOG   = 3'd3,
        KIND_UNCLOG = 3'd4
    } kind_e;

endpackage

// File: rtl/iqh_decode.sv
// Turns the kind field of a word into a kind_e value.
// Assumes the caller passes only the kind field. Every unlisted code is
// an ordinary instruction.
module iqh_decode
    import iqh_pkg::*;
(
    input  logic [KIND_W-1:0] kind_field,
    output kind_e             kind
);

    // Map each control code to its kind; everything else is plain.
    always_comb begin
        unique case (kind_field)
            CODE_INT:    kind = KIND_INT;
            CODE_MASS:   kind = KIND_MASS;
            CODE_CLOG:   kind = KIND_CLOG;
            CODE_UNCLOG: kind = KIND_UNCLOG;
            default:     kind = KIND_PLAIN;
        endcase
    end

endmodule

// File: rtl/iqh_ring.sv
// Circular buffer of DEPTH words with push, pop and a flush.
// Assumes the caller never pops when empty and never pushes while full
// unless it pops in the same cycle. Flush beats push and pop.
module iqh_ring #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 37
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_word,
    input  logic             pop,
    input  logic             flush,
    output logic [WIDTH-1:0] head_word,
    output logic             full,
    output logic             empty
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [WIDTH-1:0] slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
    endfunction

    // Store the pushed word in the tail slot.
    always_ff @(posedge clk) begin
        if (push && !flush) begin
            slots[wr_ptr] <= push_word;
        end
    end

    // Advance the write and read pointers around the ring.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
        end
    end

    // Track the number of words held.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            count <= '0;
        end else begin
            unique case ({push, pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    assign head_word = slots[rd_ptr];
    assign full      = (count == FULL_CNT);
    assign empty     = (count == '0);

endmodule

// File: rtl/iqh_arrival.sv
// Arrival register with no buffer in front of it. It decides when a
// parked control word fires against the on-deck stage and when an
// ordinary word (or a clog) moves into the ring.
// Assumes slot_free already accounts for reloop priority and for the pop
// made in the same cycle.
module iqh_arrival
    import iqh_pkg::*;
#(
    parameter int WIDTH  = 37,
    parameter int INSN_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_word,
    output logic             in_ready,
    input  logic             od_v,
    input  logic             od_im,
    input  logic             od_is_clog,
    input  logic             slot_free,
    output logic             arr_v,
    output logic [WIDTH-1:0] arr_word,
    output kind_e            arr_kind,
    output logic             fire_int,
    output logic             fire_mas,
    output logic             fire_unc,
    output logic             arr_push
);

    localparam int KIND_HI = INSN_W - 2;

    logic armed;
    logic travels;
    logic leave;

    iqh_decode u_arr_dec (
        .kind_field (arr_word[KIND_HI -: KIND_W]),
        .kind       (arr_kind)
    );

    // Decide which action, if any, the held word takes this cycle.
    always_comb begin
        armed    = od_v && !od_is_clog && od_im;
        travels  = (arr_kind == KIND_PLAIN) || (arr_kind == KIND_CLOG);
        fire_int = arr_v && (arr_kind == KIND_INT)    && armed;
        fire_mas = arr_v && (arr_kind == KIND_MASS)   && armed;
        fire_unc = arr_v && (arr_kind == KIND_UNCLOG) && od_is_clog;
        arr_push = arr_v && travels && slot_free;
        leave    = arr_push || fire_int || fire_mas || fire_unc;
        in_ready = !arr_v || leave;
    end

    // Hold or replace the arrival word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_v    <= 1'b0;
            arr_word <= '0;
        end else if (in_valid && in_ready) begin
            arr_v    <= 1'b1;
            arr_word <= in_word;
        end else if (leave) begin
            arr_v    <= 1'b0;
        end
    end

endmodule

// File: rtl/iqh_ondeck.sv
// On-deck register that holds the next word for the sequencer.
// Assumes load and clear never both need to win: a load replaces the
// leaving word, and clear only empties the stage.
module iqh_ondeck #(
    parameter int WIDTH = 37
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_word,
    input  logic             clear,
    output logic             od_v,
    output logic [WIDTH-1:0] od_word
);

    // Refill from the ring head, or empty after the word leaves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            od_v    <= 1'b0;
            od_word <= '0;
        end else if (load) begin
            od_v    <= 1'b1;
            od_word <= load_word;
        end else if (clear) begin
            od_v    <= 1'b0;
        end
    end

endmodule

// File: rtl/iqh_head.sv
// Queue head: arrival register, ring of DEPTH words and on-deck
// register. Handles interrupt, massacre, clog and unclog at the two ends
// of the queue. Assumes the sequencer asserts od_reloop only together
// with od_ready; od_reloop is also read in the cycle an interrupt fires.
module iqh_head
    import iqh_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int INSN_W = 26,
    parameter int PATH_W = 11
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [PATH_W+INSN_W-1:0] in_word,
    output logic                     od_valid,
    input  logic                     od_ready,
    output logic [PATH_W+INSN_W-1:0] od_word,
    input  logic                     od_reloop,
    output logic                     fifo_full,
    output logic                     fifo_empty
);

    localparam int WORD_W  = PATH_W + INSN_W;
    localparam int IM_BIT  = INSN_W - 1;
    localparam int KIND_HI = INSN_W - 2;

    logic              arr_v_q;
    logic [WORD_W-1:0] arr_word_q;
    kind_e             arr_kind;
    logic              fire_int;
    logic              fire_mas;
    logic              fire_unc;
    logic              arr_push;
    logic              od_v_q;
    logic [WORD_W-1:0] od_word_q;
    kind_e             od_kind;
    logic              od_im;
    logic              od_is_clog;
    logic              od_take;
    logic              od_leave;
    logic              reloop_push;
    logic              ring_pop;
    logic              ring_push;
    logic [WORD_W-1:0] ring_push_word;
    logic [WORD_W-1:0] ring_head;
    logic              ring_full;
    logic              ring_empty;
    logic              slot_free;

    iqh_decode u_od_dec (
        .kind_field (od_word_q[KIND_HI -: KIND_W]),
        .kind       (od_kind)
    );

    // On-deck status and the handshake with the sequencer.
    always_comb begin
        od_im       = od_word_q[IM_BIT];
        od_is_clog  = od_v_q && (od_kind == KIND_CLOG);
        od_valid    = od_v_q && !od_is_clog && !fire_int && !fire_mas;
        od_take     = od_valid && od_ready;
        od_leave    = od_take || fire_int || fire_mas || fire_unc;
        reloop_push = (od_take || fire_int) && od_reloop;
    end

    // Ring traffic: refill on deck, reloop first, then arrivals.
    always_comb begin
        ring_pop       = !ring_empty && (!od_v_q || od_leave) && !fire_mas;
        slot_free      = !reloop_push && (!ring_full || ring_pop);
        ring_push      = reloop_push || arr_push;
        ring_push_word = reloop_push ? od_word_q : arr_word_q;
    end

    iqh_arrival #(
        .WIDTH  (WORD_W),
        .INSN_W (INSN_W)
    ) u_arrival (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_word    (in_word),
        .in_ready   (in_ready),
        .od_v       (od_v_q),
        .od_im      (od_im),
        .od_is_clog (od_is_clog),
        .slot_free  (slot_free),
        .arr_v      (arr_v_q),
        .arr_word   (arr_word_q),
        .arr_kind   (arr_kind),
        .fire_int   (fire_int),
        .fire_mas   (fire_mas),
        .fire_unc   (fire_unc),
        .arr_push   (arr_push)
    );

    iqh_ring #(
        .DEPTH (DEPTH),
        .WIDTH (WORD_W)
    ) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ring_push),
        .push_word (ring_push_word),
        .pop       (ring_pop),
        .flush     (fire_mas),
        .head_word (ring_head),
        .full      (ring_full),
        .empty     (ring_empty)
    );

    iqh_ondeck #(
        .WIDTH (WORD_W)
    ) u_ondeck (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ring_pop),
        .load_word (ring_head),
        .clear     (od_leave || fire_mas),
        .od_v      (od_v_q),
        .od_word   (od_word_q)
    );

    assign od_word    = od_word_q;
    assign fifo_full  = ring_full;
    assign fifo_empty = ring_empty;

endmodule

// File: rtl/iqh_head_chk.sv
// Temporal checks on the queue head, bound to every iqh_head instance.
// Assumes the bind below connects the top's internal stage state.
module iqh_head_chk
    import iqh_pkg::*;
#(
    parameter int WORD_W = 37,
    parameter int IM_BIT = 25
) (
    input logic              clk,
    input logic              rst_n,
    input logic              od_valid,
    input logic              od_ready,
    input logic [WORD_W-1:0] od_word,
    input logic              fifo_full,
    input logic              fifo_empty,
    input logic              arr_v,
    input logic [WORD_W-1:0] arr_word,
    input kind_e             arr_kind,
    input logic              od_v,
    input logic              od_is_clog,
    input logic              fire_mas,
    input logic              fire_unc,
    input logic              ring_push,
    input logic              ring_pop
);

    // R1: a reset edge leaves the ring and on-deck stage empty.
    assert_reset_empties_R1: assert property (@(posedge clk)
        !rst_n |=> (fifo_empty && !od_valid));

    // R2: an offered word that is not taken stays offered and stable.
    assert_offer_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (od_valid && !od_ready) |=> (od_v && $stable(od_word)));

    // R3: no net push into a full ring.
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && ring_push) |-> ring_pop);

    // R6: an interrupt or massacre without an armed on-deck word stays put.
    assert_ctrl_waits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_v && (arr_kind == KIND_INT || arr_kind == KIND_MASS)
         && !(od_v && !od_is_clog && od_word[IM_BIT]))
        |=> (arr_v && $stable(arr_word)));

    // R8: a massacre leaves nothing behind in the ring or on deck.
    assert_massacre_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fire_mas |=> (fifo_empty && !od_v));

    // R9: a clog on deck stays there until an unclog meets it.
    assert_clog_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (od_is_clog && !fire_unc) |=> (od_is_clog && $stable(od_word)));

    // R11: an unclog with no clog on deck keeps waiting.
    assert_unclog_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_v && arr_kind == KIND_UNCLOG && !od_is_clog)
        |=> (arr_v && $stable(arr_word)));

endmodule

bind iqh_head iqh_head_chk #(
    .WORD_W (WORD_W),
    .IM_BIT (IM_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .od_valid   (od_valid),
    .od_ready   (od_ready),
    .od_word    (od_word),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .arr_v      (arr_v_q),
    .arr_word   (arr_word_q),
    .arr_kind   (arr_kind),
    .od_v       (od_v_q),
    .od_is_clog (od_is_clog),
    .fire_mas   (fire_mas),
    .fire_unc   (fire_unc),
    .ring_push  (ring_push),
    .ring_pop   (ring_pop)
);

// File: tb/iqh_head_tb.sv
// Self-checking bench for iqh_head. A behavioural queue model is
// stepped every clock, and each output is compared with it away from
// the edge.
module iqh_head_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 3;
    localparam int INSN_W     = 26;
    localparam int PATH_W     = 11;
    localparam int WORD_W     = PATH_W + INSN_W;
    localparam int WATCHDOG   = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [WORD_W-1:0] in_word = '0;
    logic              od_valid;
    logic              od_ready = 1'b0;
    logic [WORD_W-1:0] od_word;
    logic              od_reloop = 1'b0;
    logic              fifo_full;
    logic              fifo_empty;

    iqh_head #(
        .DEPTH  (DEPTH),
        .INSN_W (INSN_W),
        .PATH_W (PATH_W)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_word    (in_word),
        .od_valid   (od_valid),
        .od_ready   (od_ready),
        .od_word    (od_word),
        .od_reloop  (od_reloop),
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cycles   = 0;
    string cur_req  = "R1";

    // Reference state: arrival slot, ring as a queue, on-deck slot.
    logic [WORD_W-1:0] mq[$];
    logic              m_arr_v = 1'b0;
    logic [WORD_W-1:0] m_arr_w = '0;
    logic              m_od_v  = 1'b0;
    logic [WORD_W-1:0] m_od_w  = '0;

    // Expected outputs and decisions for the current cycle.
    logic e_in_ready, e_od_valid, e_full, e_empty;
    logic f_int, f_mas, f_unc, take, leave, rpush, pop, apush, aleave;

    always @(posedge clk) cycles++;

    // Kind from bits 24:21: 0 plain, 1 interrupt, 2 massacre, 3 clog, 4 unclog.
    function automatic int kind_of(logic [WORD_W-1:0] w);
        case (w[24:21])
            4'hC:    return 1;
            4'hD:    return 2;
            4'hE:    return 3;
            4'hF:    return 4;
            default: return 0;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] mk(int k, bit im);
        logic [WORD_W-1:0] w;
        w[36:26] = 11'($urandom);
        w[25]    = im;
        case (k)
            1:       w[24:21] = 4'hC;
            2:       w[24:21] = 4'hD;
            3:       w[24:21] = 4'hE;
            4:       w[24:21] = 4'hF;
            default: w[24:21] = 4'($urandom_range(0, 11));
        endcase
        w[20:0] = 21'($urandom);
        return w;
    endfunction

    task automatic eval();
        int  ak = kind_of(m_arr_w);
        int  ok = kind_of(m_od_w);
        bit  od_clog = m_od_v && ok == 3;
        bit  armed   = m_od_v && !od_clog && m_od_w[25];
        f_int      = m_arr_v && ak == 1 && armed;
        f_mas      = m_arr_v && ak == 2 && armed;
        f_unc      = m_arr_v && ak == 4 && od_clog;
        e_od_valid = m_od_v && !od_clog && !f_int && !f_mas;
        take       = e_od_valid && od_ready;
        leave      = take || f_int || f_mas || f_unc;
        rpush      = (take || f_int) && od_reloop;
        pop        = mq.size() > 0 && (!m_od_v || leave) && !f_mas;
        apush      = m_arr_v && (ak == 0 || ak == 3) && !rpush
                     && (mq.size() < DEPTH || pop);
        aleave     = apush || f_int || f_mas || f_unc;
        e_in_ready = !m_arr_v || aleave;
        e_full     = mq.size() == DEPTH;
        e_empty    = mq.size() == 0;
    endtask

    task automatic step_model();
        logic [WORD_W-1:0] old_od = m_od_w;
        logic [WORD_W-1:0] old_arr = m_arr_w;
        if (!rst_n) begin
            mq.delete();
            m_arr_v = 1'b0;
            m_od_v  = 1'b0;
            m_od_w  = '0;
            m_arr_w = '0;
        end else begin
            if (f_mas) begin
                mq.delete();
                m_od_v = 1'b0;
            end else begin
                if (pop) begin
                    m_od_w = mq.pop_front();
                    m_od_v = 1'b1;
                end else if (leave) begin
                    m_od_v = 1'b0;
                end
                if (rpush)      mq.push_back(old_od);
                else if (apush) mq.push_back(old_arr);
            end
            if (in_valid && e_in_ready) begin
                m_arr_v = 1'b1;
                m_arr_w = in_word;
            end else if (aleave) begin
                m_arr_v = 1'b0;
            end
        end
    endtask

    task automatic check(string what, logic [WORD_W-1:0] act, logic [WORD_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, compare, then step the model.
    task automatic tick(bit v, logic [WORD_W-1:0] w, bit rdy, bit rl);
        @(negedge clk);
        in_valid  = v;
        in_word   = w;
        od_ready  = rdy;
        od_reloop = rl;
        #1;
        if (rst_n) begin
            eval();
            check("in_ready",   {36'd0, in_ready},   {36'd0, e_in_ready});
            check("od_valid",   {36'd0, od_valid},   {36'd0, e_od_valid});
            check("fifo_full",  {36'd0, fifo_full},  {36'd0, e_full});
            check("fifo_empty", {36'd0, fifo_empty}, {36'd0, e_empty});
            if (e_od_valid) check("od_word", od_word, m_od_w);
        end
        @(posedge clk);
        step_model();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick(1'b0, '0, 1'b0, 1'b0);
        tick(1'b0, '0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Random traffic; mode picks the mix of kinds and handshake rates.
    task automatic run(string tag, int n, int mode);
        cur_req = tag;
        for (int i = 0; i < n; i++) begin
            int r  = $urandom_range(0, 99);
            int k  = 0;
            bit im = 1'($urandom_range(0, 1));
            bit v  = $urandom_range(0, 99) < 70;
            bit rdy = (mode == 1) ? ($urandom_range(0, 99) < 20)
                                  : ($urandom_range(0, 99) < 70);
            bit rl = (mode >= 2) && ($urandom_range(0, 99) < 35);
            if (mode >= 4 && (i % 64) == 63) begin
                do_reset();
                cur_req = tag;
            end
            case (mode)
                4: if (r < 10) k = 1;
                5: if (r < 8) k = 1; else if (r < 16) k = 2;
                6: if (r < 10) k = 3; else if (r < 20) k = 4;
                7: begin
                    if (r < 10) begin k = 3; im = 1'b1; end
                    else if (r < 15) k = 1;
                    else if (r < 20) k = 2;
                    else if (r < 25) k = 4;
                end
                default: k = 0;
            endcase
            tick(v, mk(k, im), rdy, rl);
        end
    endtask

    initial begin : watchdog
        wait (cycles >= WATCHDOG);
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        // R1: state right after reset.
        do_reset();
        cur_req = "R1";
        tick(1'b0, '0, 1'b0, 1'b0);
        check("reset in_ready",   {36'd0, in_ready},   37'd1);
        check("reset od_valid",   {36'd0, od_valid},   37'd0);
        check("reset fifo_empty", {36'd0, fifo_empty}, 37'd1);

        // R2: ordinary words in order; R3: filling the ring.
        run("R2", 1500, 0);
        do_reset();
        cur_req = "R3";
        for (int i = 0; i < DEPTH + 4; i++) tick(1'b1, mk(0, 1'b0), 1'b0, 1'b0);
        check("full after stall", {36'd0, fifo_full}, 37'd1);
        check("in_ready at full", {36'd0, in_ready},  37'd0);
        run("R3", 1500, 1);

        // R4: reloop requests; R5: every ordinary code passes unchanged.
        run("R4", 2000, 2);
        run("R5", 1000, 3);

        // R6: interrupt parks while the on-deck word is not interruptible.
        do_reset();
        cur_req = "R6";
        tick(1'b1, mk(0, 1'b0), 1'b0, 1'b0);
        tick(1'b1, mk(1, 1'b0), 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) tick(1'b0, '0, 1'b0, 1'b0);
        check("interrupt parked", {36'd0, in_ready}, 37'd0);
        tick(1'b0, '0, 1'b1, 1'b0);
        tick(1'b0, '0, 1'b1, 1'b0);

        // R7: interrupt against an interruptible word, with reloop.
        do_reset();
        cur_req = "R7";
        tick(1'b1, mk(0, 1'b1), 1'b0, 1'b0);
        tick(1'b1, mk(0, 1'b0), 1'b0, 1'b0);
        tick(1'b1, mk(1, 1'b0), 1'b0, 1'b0);
        for (int i = 0; i < 6; i++) tick(1'b0, '0, 1'b0, 1'b1);
        for (int i = 0; i < 6; i++) tick(1'b0, '0, 1'b1, 1'b0);
        run("R7", 2000, 4);

        // R8: massacre empties the queue.
        do_reset();
        cur_req = "R8";
        tick(1'b1, mk(0, 1'b1), 1'b0, 1'b0);
        tick(1'b1, mk(0, 1'b0), 1'b0, 1'b0);
        tick(1'b1, mk(0, 1'b0), 1'b0, 1'b0);
        tick(1'b1, mk(2, 1'b0), 1'b0, 1'b0);
        for (int i = 0; i < 6; i++) tick(1'b0, '0, 1'b0, 1'b0);
        check("empty after massacre", {36'd0, fifo_empty}, 37'd1);
        check("nothing on deck",      {36'd0, od_valid},   37'd0);
        run("R8", 2000, 5);

        // R9: clog blocks what follows; R10: unclog releases it.
        do_reset();
        cur_req = "R9";
        tick(1'b1, mk(3, 1'b0), 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) tick(1'b1, mk(0, 1'b0), 1'b1, 1'b0);
        for (int i = 0; i < 6; i++) tick(1'b0, '0, 1'b1, 1'b0);
        check("clog not offered", {36'd0, od_valid}, 37'd0);
        cur_req = "R10";
        tick(1'b1, mk(4, 1'b0), 1'b1, 1'b0);
        for (int i = 0; i < 8; i++) tick(1'b0, '0, 1'b1, 1'b0);
        check("drained after unclog", {36'd0, fifo_empty}, 37'd1);
        run("R10", 2000, 6);

        // R11: unclog with no clog anywhere never moves.
        do_reset();
        cur_req = "R11";
        tick(1'b1, mk(4, 1'b0), 1'b1, 1'b0);
        for (int i = 0; i < 40; i++) tick(1'b1, mk(0, 1'b0), 1'b1, 1'b0);
        check("unclog deadlock", {36'd0, in_ready}, 37'd0);

        // R12: a clog with its flag set does not arm an interrupt.
        do_reset();
        cur_req = "R12";
        tick(1'b1, mk(3, 1'b1), 1'b1, 1'b0);
        tick(1'b1, mk(1, 1'b0), 1'b1, 1'b0);
        for (int i = 0; i < 6; i++) tick(1'b0, '0, 1'b1, 1'b0);
        check("interrupt ignores clog", {36'd0, in_ready}, 37'd0);
        run("R12", 2000, 7);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule